// File: doc/BRIEF.md
# Two-Stage Operand Pipeline Sequencer

This block sequences a two-stage execution pipeline. Stage one performs decode, address-component select and register operand fetch. Stage two performs address generation or execution. Each accepted instruction carries a 2-bit class. The sequencer expands it into one or more passes through the two stages, and it drives one enable per stage function on every cycle, together with memory read and write requests.

The register file, ALU and memory system lie outside the block and are seen only through these enables and a read-data-valid input. The `ready_o` output is the accept handshake, so an upstream fetch unit can present the next instruction whenever one is available. A tag supplied with each instruction comes back on `ex_tag_o` in the cycle that the instruction executes, which lets the datapath tie results to instructions.

Register-to-register and store instructions take one cycle of stage one. A load takes two passes and can stall on memory. A read-modify-write instruction is a load followed by a store pass.

Top module: `opseq_top`

## Requirements
- R1: After reset, `ready_o` is high and every enable, request and `ex_tag_o` is low.
- R2: Class 00 (register-to-register) occupies stage one for one cycle with `ds_en_o` and `oc_en_o` high. The next cycle has `ex_en_o` high. Instructions of this class can be accepted on consecutive cycles.
- R3: The first pass of class 01 (memory-to-register) or class 11 (read-modify-write) drives `ds_en_o` alone in stage one. The next cycle has `ag_en_o` high.
- R4: The second pass of class 01 or 11 holds `rd_req_o` high in stage one and raises `oc_en_o` in the cycle that `rd_valid_i` is high. The next cycle has `ex_en_o` high.
- R5: Class 10 (register-to-memory) occupies stage one for one cycle with `ds_en_o` and `oc_en_o`. The next cycle has `ag_en_o`, `ex_en_o` and `wr_req_o` high together.
- R6: Class 11 adds a third pass after its second pass. That pass has `ds_en_o` alone in stage one, then `ag_en_o` and `wr_req_o` in the next cycle.
- R7: While `rd_req_o` is high and `rd_valid_i` is low, the second pass stays in stage one. During that time `rd_req_o` stays high, `oc_en_o` and `ready_o` are low, and stage two receives no work.
- R8: `ready_o` is high when stage one is empty, and in the cycle that the last pass of the current instruction leaves stage one. An instruction is taken on a rising clock edge with `ready_o` and `instr_valid_i` both high, and it occupies stage one in the next cycle.
- R9: Whenever `ex_en_o` is high, `ex_tag_o` equals the tag given with the instruction that is executing.
- R10: `rd_valid_i` has no effect on any output while `rd_req_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | An instruction is offered |
| instr_class_i | input | 2 | Class: 00 reg-reg, 01 mem-to-reg, 10 reg-to-mem, 11 read-modify-write |
| instr_tag_i | input | TAG_W | Tag of the offered instruction |
| rd_valid_i | input | 1 | Memory read data valid |
| ready_o | output | 1 | Next instruction can be accepted |
| ds_en_o | output | 1 | Decode / address-component select enable |
| oc_en_o | output | 1 | Operand fetch enable |
| ag_en_o | output | 1 | Address generate enable |
| ex_en_o | output | 1 | Execute enable |
| rd_req_o | output | 1 | Memory read request |
| wr_req_o | output | 1 | Memory write request |
| ex_tag_o | output | TAG_W | Tag of the executing instruction |

## Verification
The bench builds the block with the default tag width of 4, which is enough to give every instruction in a run a distinct tag. It sweeps every ordered triple of the four classes, which is 64 combinations. Each triple runs under three read latencies: zero, one and three wait cycles. Half of the runs also hold `rd_valid_i` high outside load passes. This covers every pairing of a pass with the pass that follows it, stalls of every length that matters, and the case where read-valid arrives while no read is outstanding. The bench compares every output against a cycle timeline that it computes from the pass lists and the latencies.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  typedef enum logic [1:0] {
    CLS_RR  = 2'b00,
    CLS_MR  = 2'b01,
    CLS_RM  = 2'b10,
    CLS_RMW = 2'b11
  } op_class_e;

  typedef enum logic [2:0] {
    PASS_RR    = 3'd0,
    PASS_RM    = 3'd1,
    PASS_ADDR  = 3'd2,
    PASS_LOAD  = 3'd3,
    PASS_STORE = 3'd4
  } pass_e;

  function automatic pass_e first_pass(op_class_e cls);
    case (cls)
      CLS_RR:  return PASS_RR;
      CLS_RM:  return PASS_RM;
      default: return PASS_ADDR;
    endcase
  endfunction

  function automatic pass_e next_pass(op_class_e cls, pass_e cur);
    case (cur)
      PASS_ADDR: return PASS_LOAD;
      PASS_LOAD: return (cls == CLS_RMW) ? PASS_STORE : PASS_LOAD;
      default:   return cur;
    endcase
  endfunction

  function automatic logic is_last_pass(op_class_e cls, pass_e cur);
    case (cur)
      PASS_RR, PASS_RM, PASS_STORE: return 1'b1;
      PASS_LOAD:                    return cls == CLS_MR;
      default:                      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/opseq_front.sv
module opseq_front
  import opseq_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  input  op_class_e        instr_class_i,
  input  logic [TAG_W-1:0] instr_tag_i,
  input  logic             rd_valid_i,
  output logic             ready_o,
  output logic             hand_vld_o,
  output pass_e            hand_pass_o,
  output logic [TAG_W-1:0] hand_tag_o,
  output logic             ds_en_o,
  output logic             oc_en_o,
  output logic             rd_req_o
);

  logic             s1_vld_q;
  op_class_e        s1_cls_q;
  pass_e            s1_pass_q;
  logic [TAG_W-1:0] s1_tag_q;

  logic is_load, stall, advance, last, take;

  assign is_load = s1_vld_q && (s1_pass_q == PASS_LOAD);
  assign stall   = is_load && !rd_valid_i;
  assign advance = s1_vld_q && !stall;
  assign last    = is_last_pass(s1_cls_q, s1_pass_q);
  assign ready_o = !s1_vld_q || (advance && last);
  assign take    = ready_o && instr_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q  <= 1'b0;
      s1_cls_q  <= CLS_RR;
      s1_pass_q <= PASS_RR;
      s1_tag_q  <= '0;
    end else if (take) begin
      s1_vld_q  <= 1'b1;
      s1_cls_q  <= instr_class_i;
      s1_pass_q <= first_pass(instr_class_i);
      s1_tag_q  <= instr_tag_i;
    end else if (advance) begin
      if (last) s1_vld_q <= 1'b0;
      else      s1_pass_q <= next_pass(s1_cls_q, s1_pass_q);
    end
  end

  assign hand_vld_o  = advance;
  assign hand_pass_o = s1_pass_q;
  assign hand_tag_o  = s1_tag_q;

  always_comb begin
    ds_en_o  = 1'b0;
    oc_en_o  = 1'b0;
    rd_req_o = 1'b0;
    if (s1_vld_q) begin
      case (s1_pass_q)
        PASS_RR, PASS_RM: begin
          ds_en_o = 1'b1;
          oc_en_o = 1'b1;
        end
        PASS_ADDR, PASS_STORE: ds_en_o = 1'b1;
        PASS_LOAD: begin
          rd_req_o = 1'b1;
          oc_en_o  = rd_valid_i;  // register operand taken with memory data
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/opseq_back.sv
module opseq_back
  import opseq_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hand_vld_i,
  input  pass_e            hand_pass_i,
  input  logic [TAG_W-1:0] hand_tag_i,
  output logic             ag_en_o,
  output logic             ex_en_o,
  output logic             wr_req_o,
  output logic [TAG_W-1:0] ex_tag_o
);

  logic             s2_vld_q;
  pass_e            s2_pass_q;
  logic [TAG_W-1:0] s2_tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld_q  <= 1'b0;
      s2_pass_q <= PASS_RR;
      s2_tag_q  <= '0;
    end else begin
      s2_vld_q <= hand_vld_i;
      if (hand_vld_i) begin
        s2_pass_q <= hand_pass_i;
        s2_tag_q  <= hand_tag_i;
      end
    end
  end

  always_comb begin
    ag_en_o  = 1'b0;
    ex_en_o  = 1'b0;
    wr_req_o = 1'b0;
    if (s2_vld_q) begin
      case (s2_pass_q)
        PASS_RR, PASS_LOAD: ex_en_o = 1'b1;
        PASS_RM: begin
          ag_en_o  = 1'b1;
          ex_en_o  = 1'b1;
          wr_req_o = 1'b1;
        end
        PASS_ADDR: ag_en_o = 1'b1;
        PASS_STORE: begin
          ag_en_o  = 1'b1;
          wr_req_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign ex_tag_o = ex_en_o ? s2_tag_q : '0;

endmodule

// File: rtl/opseq_top.sv
module opseq_top
  import opseq_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  input  logic [1:0]       instr_class_i,
  input  logic [TAG_W-1:0] instr_tag_i,
  input  logic             rd_valid_i,
  output logic             ready_o,
  output logic             ds_en_o,
  output logic             oc_en_o,
  output logic             ag_en_o,
  output logic             ex_en_o,
  output logic             rd_req_o,
  output logic             wr_req_o,
  output logic [TAG_W-1:0] ex_tag_o
);

  logic             hand_vld;
  pass_e            hand_pass;
  logic [TAG_W-1:0] hand_tag;

  opseq_front #(.TAG_W(TAG_W)) i_front (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .instr_valid_i (instr_valid_i),
    .instr_class_i (op_class_e'(instr_class_i)),
    .instr_tag_i   (instr_tag_i),
    .rd_valid_i    (rd_valid_i),
    .ready_o       (ready_o),
    .hand_vld_o    (hand_vld),
    .hand_pass_o   (hand_pass),
    .hand_tag_o    (hand_tag),
    .ds_en_o       (ds_en_o),
    .oc_en_o       (oc_en_o),
    .rd_req_o      (rd_req_o)
  );

  opseq_back #(.TAG_W(TAG_W)) i_back (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hand_vld_i  (hand_vld),
    .hand_pass_i (hand_pass),
    .hand_tag_i  (hand_tag),
    .ag_en_o     (ag_en_o),
    .ex_en_o     (ex_en_o),
    .wr_req_o    (wr_req_o),
    .ex_tag_o    (ex_tag_o)
  );

endmodule

// File: rtl/opseq_chk.sv
module opseq_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             instr_valid_i,
  input logic [1:0]       instr_class_i,
  input logic [TAG_W-1:0] instr_tag_i,
  input logic             rd_valid_i,
  input logic             ready_o,
  input logic             ds_en_o,
  input logic             oc_en_o,
  input logic             ag_en_o,
  input logic             ex_en_o,
  input logic             rd_req_o,
  input logic             wr_req_o,
  input logic [TAG_W-1:0] ex_tag_o
);

  // R2
  rr_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && instr_valid_i && instr_class_i == 2'b00 |=> ds_en_o && oc_en_o && !rd_req_o);

  // R3
  load_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && instr_valid_i && instr_class_i[0] |=> ds_en_o && !oc_en_o && !rd_req_o);

  // R3
  addr_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_en_o && !oc_en_o |=> ag_en_o && !ex_en_o);

  // R4
  load_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && rd_valid_i |=> ex_en_o && !ag_en_o);

  // R5
  store_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ag_en_o && ex_en_o |-> wr_req_o);

  // R6
  write_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> ag_en_o);

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |-> !ready_o && !oc_en_o);

  // R7
  stall_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o && !ag_en_o && !ex_en_o);

  // R9
  idle_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_en_o |-> ex_tag_o == '0);

endmodule

bind opseq_top opseq_chk #(.TAG_W(TAG_W)) i_opseq_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_valid_i (instr_valid_i),
  .instr_class_i (instr_class_i),
  .instr_tag_i   (instr_tag_i),
  .rd_valid_i    (rd_valid_i),
  .ready_o       (ready_o),
  .ds_en_o       (ds_en_o),
  .oc_en_o       (oc_en_o),
  .ag_en_o       (ag_en_o),
  .ex_en_o       (ex_en_o),
  .rd_req_o      (rd_req_o),
  .wr_req_o      (wr_req_o),
  .ex_tag_o      (ex_tag_o)
);

// File: tb/test_opseq_top.sv
`timescale 1ns/1ps
module test_opseq_top;

  localparam int TAG_W = 4;
  localparam int MAXC  = 32;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             instr_valid_i = 1'b0;
  logic [1:0]       instr_class_i = '0;
  logic [TAG_W-1:0] instr_tag_i = '0;
  logic             rd_valid_i = 1'b0;
  logic             ready_o, ds_en_o, oc_en_o, ag_en_o, ex_en_o, rd_req_o, wr_req_o;
  logic [TAG_W-1:0] ex_tag_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  opseq_top #(.TAG_W(TAG_W)) i_opseq_top (.*);

  // bits: 6 ready, 5 ds, 4 oc, 3 ag, 2 ex, 1 rd, 0 wr
  logic [6:0]       ev  [MAXC];
  logic [TAG_W-1:0] et  [MAXC];
  logic             rv  [MAXC];
  string            lab [MAXC];
  int               cl  [3];
  logic [TAG_W-1:0] tg  [3];

  // pass kinds: 0 reg-reg, 1 reg-mem, 2 addr, 3 load, 4 store
  function automatic int pass_kind(int cls, int p);
    case (cls)
      0: return 0;
      2: return 1;
      default: return (p == 0) ? 2 : (p == 1) ? 3 : 4;
    endcase
  endfunction

  function automatic int pass_cnt(int cls);
    return (cls == 1) ? 2 : (cls == 3) ? 3 : 1;
  endfunction

  task automatic build(input int d, input logic bg, output int total);
    int t;
    t = 1;
    for (int n = 0; n < MAXC; n++) begin
      ev[n] = '0; et[n] = '0; rv[n] = bg; lab[n] = "R8";
    end
    ev[0][6] = 1'b1; lab[0] = "R1";
    for (int i = 0; i < 3; i++) begin
      for (int p = 0; p < pass_cnt(cl[i]); p++) begin
        int k, dur;
        k   = pass_kind(cl[i], p);
        dur = (k == 3) ? d + 1 : 1;
        for (int j = 0; j < dur; j++) begin
          case (k)
            0: begin ev[t+j][5] = 1; ev[t+j][4] = 1; lab[t+j] = "R2"; end
            1: begin ev[t+j][5] = 1; ev[t+j][4] = 1; lab[t+j] = "R5"; end
            2: begin ev[t+j][5] = 1; lab[t+j] = "R3"; end
            3: begin
              ev[t+j][1] = 1;
              rv[t+j] = (j == dur - 1);
              ev[t+j][4] = (j == dur - 1);
              lab[t+j] = (j == dur - 1) ? "R4" : "R7";
            end
            default: begin ev[t+j][5] = 1; lab[t+j] = "R6"; end
          endcase
        end
        if (p == pass_cnt(cl[i]) - 1) ev[t+dur-1][6] = 1'b1;
        case (k)
          0, 3: begin ev[t+dur][2] = 1; et[t+dur] = tg[i]; end
          1: begin ev[t+dur][3] = 1; ev[t+dur][2] = 1; ev[t+dur][0] = 1; et[t+dur] = tg[i]; end
          2: ev[t+dur][3] = 1;
          default: begin ev[t+dur][3] = 1; ev[t+dur][0] = 1; end
        endcase
        t += dur;
      end
    end
    for (int n = t; n < MAXC; n++) ev[n][6] = 1'b1;
    total = t + 2;
  endtask

  task automatic run(input int sc, input int d);
    int total, idx;
    logic bg;
    logic [6:0] act;
    bg = sc[0];
    for (int i = 0; i < 3; i++) tg[i] = TAG_W'((sc * 3 + i) % 15 + 1);
    build(d, bg, total);
    rst_ni = 1'b0;
    instr_valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    idx = 0;
    for (int n = 0; n < total; n++) begin
      instr_valid_i = (idx < 3);
      instr_class_i = (idx < 3) ? 2'(cl[idx]) : 2'b00;
      instr_tag_i   = (idx < 3) ? tg[idx] : '0;
      rd_valid_i    = rv[n];
      #1;
      act = {ready_o, ds_en_o, oc_en_o, ag_en_o, ex_en_o, rd_req_o, wr_req_o};
      n_cmp++;
      if (act !== ev[n]) begin
        n_bad++;
        // R10 named when read-valid was high with no read expected
        $display("FAIL %s%s cyc %0d cls %0d/%0d/%0d lat %0d: got %b exp %b",
                 (act[6] !== ev[n][6]) ? "R8" : lab[n],
                 (rv[n] && !ev[n][1]) ? " R10" : "", n, cl[0], cl[1], cl[2], d, act, ev[n]);
      end
      if (ev[n][2]) begin
        n_cmp++;
        if (ex_tag_o !== et[n]) begin
          n_bad++;
          $display("FAIL R9 cyc %0d: got tag %0d exp %0d", n, ex_tag_o, et[n]);
        end
      end
      if (ready_o && instr_valid_i) idx++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: got hang exp finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int sc, lat;
    sc = 0;
    repeat (2) @(negedge clk_i);
    for (int li = 0; li < 3; li++) begin
      lat = (li == 2) ? 3 : li;
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 4; c++) begin
            cl[0] = a; cl[1] = b; cl[2] = c;
            run(sc, lat);
            sc++;
          end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule